// File: doc/BRIEF.md
# Lowest-Area Address Decoder with Long-Wait Insertion

This block sits between the CPU address path and the lowest memory area. For every access strobe it decides whether the address falls into the area. It then uses three mode pins to pick the target, either a 32-bit internal ROM or an 8-bit or 16-bit external memory. It produces the folded address that the target sees, so that the mirrored images of the area all reach the same storage.

An internal ROM access finishes at once: a ROM select pulses for one cycle together with ready, and the chip select never moves. An external access drives an active-low chip select. The cycle is stretched by one to four long-wait states, taken from a two-bit wait field that is sampled with the strobe. Address, mode and wait field are captured when the access starts. A strobe that arrives while an access is in flight is dropped.

Top module: `a0_bus_decoder`

## Requirements
- R1: A strobe in the idle state starts an access only when address bits 26..24 are all zero. Bit 27 plays no part. A strobe to any other address leaves cs_n_o high, rom_sel_o low and ready_o low.
- R2: The mode pins are decoded as follows. 3'b010 gives an internal ROM access with width code 2'b10 (32-bit). 3'b001 gives external with width code 2'b01 (16-bit). 3'b000 gives external with width code 2'b00 (8-bit). The width code is independent of address bit 27.
- R3: The mode values 3'b011 and 3'b100 through 3'b111 give an 8-bit external access, with width code 2'b00.
- R4: During a ROM access, bus_addr_o equals address bits 15..0, with every higher bit driven to zero.
- R5: A ROM access keeps cs_n_o high. It raises rom_sel_o and ready_o together in the cycle after the strobe is sampled, for exactly one cycle.
- R6: During an external access, bus_addr_o equals the captured address with bits 23 and 22 forced to zero.
- R7: An external access inserts N = field + 1 long-wait states, where the field is 0..3. cs_n_o stays low with ready_o low for N + 1 cycles, and ready_o then rises for one cycle.
- R8: ready_o is a one-cycle pulse. In the following cycle cs_n_o is high, rom_sel_o is low and the block is idle.
- R9: A strobe sampled while an access is in progress starts nothing. No extra completion follows.
- R10: The parameter FORCE_EXT=1, or ROM_PRESENT=0, makes mode 3'b010 an 8-bit external access.
- R11: Address, mode and wait field are captured at the starting edge. Changing them during the access has no effect on bus_addr_o, width_o, the target or the wait length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 28 | CPU address |
| strobe_i | input | 1 | Access request, sampled on the rising edge |
| mode_i | input | 3 | Mode pins selecting target and width |
| lw_i | input | 2 | Long-wait field (0..3 gives 1..4 waits) |
| rom_sel_o | output | 1 | Internal ROM select |
| cs_n_o | output | 1 | Active-low external chip select |
| bus_addr_o | output | 28 | Folded address for the selected target |
| width_o | output | 2 | Bus width code: 00 8-bit, 01 16-bit, 10 32-bit |
| ready_o | output | 1 | One-cycle access-complete pulse |

## Verification
A wrong wait counter shows at the ports on the first external access. ready_o arrives early or late against the N + 1 cycles of cs_n_o low, and the latency check catches this within five cycles of the strobe. A wrong sequencer state either leaves cs_n_o low after ready_o or lets a strobe arrive mid-access and produce a second completion. Both show up one cycle after the event. Capture registers that follow the inputs instead of holding them are exposed because the bench scrambles address, mode and wait field right after every strobe, so any leak changes bus_addr_o, width_o or the latency of that same access.

// File: rtl/a0_pkg.sv
package a0_pkg;

    localparam int LW_W  = 2;
    localparam int CNT_W = LW_W + 1;

    localparam logic [2:0] MODE_EXT8  = 3'b000;
    localparam logic [2:0] MODE_EXT16 = 3'b001;
    localparam logic [2:0] MODE_ROM   = 3'b010;

    typedef enum logic [1:0] {
        BW_8  = 2'b00,
        BW_16 = 2'b01,
        BW_32 = 2'b10
    } bw_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_WAIT = 2'b01,
        ST_DONE = 2'b10
    } st_e;

    typedef struct packed {
        logic is_rom;
        bw_e  width;
    } target_t;

    function automatic target_t decode_mode(input logic [2:0] m, input logic rom_ok);
        target_t t;
        t.is_rom = 1'b0;
        t.width  = BW_8;
        case (m)
            MODE_ROM: begin
                if (rom_ok) begin
                    t.is_rom = 1'b1;
                    t.width  = BW_32;
                end
            end
            MODE_EXT16: t.width = BW_16;
            default:    t.width = BW_8;
        endcase
        return t;
    endfunction

    function automatic logic [CNT_W-1:0] waits_of(input logic [LW_W-1:0] f);
        return {1'b0, f} + {{(CNT_W-1){1'b0}}, 1'b1};
    endfunction

endpackage

// File: rtl/a0_mode_decode.sv
module a0_mode_decode
    import a0_pkg::*;
#(
    parameter bit ROM_PRESENT = 1'b1,
    parameter bit FORCE_EXT   = 1'b0
) (
    input  logic [2:0] mode_i,
    output target_t    tgt_o
);
    localparam bit ROM_OK = ROM_PRESENT && !FORCE_EXT;

    generate
        if (ROM_OK) begin : g_rom
            assign tgt_o = decode_mode(mode_i, 1'b1);
        end else begin : g_ext_only
            assign tgt_o = decode_mode(mode_i, 1'b0);
        end
    endgenerate
endmodule

// File: rtl/a0_addr_fold.sv
module a0_addr_fold #(
    parameter int ADDR_W   = 28,
    parameter int AREA_HI  = 26,
    parameter int AREA_LO  = 24,
    parameter int ROM_BITS = 16,
    parameter int DROP_HI  = 23,
    parameter int DROP_LO  = 22
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o,
    output logic [ADDR_W-1:0] rom_addr_o,
    output logic [ADDR_W-1:0] ext_addr_o
);
    assign hit_o = (addr_i[AREA_HI:AREA_LO] == '0);

    generate
        for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
            if (b < ROM_BITS) begin : g_rom_keep
                assign rom_addr_o[b] = addr_i[b];
            end else begin : g_rom_zero
                assign rom_addr_o[b] = 1'b0;
            end
            if (b >= DROP_LO && b <= DROP_HI) begin : g_ext_zero
                assign ext_addr_o[b] = 1'b0;
            end else begin : g_ext_keep
                assign ext_addr_o[b] = addr_i[b];
            end
        end
    endgenerate
endmodule

// File: rtl/a0_wait_seq.sv
module a0_wait_seq
    import a0_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          rom_i,
    input  logic [CW-1:0] waits_i,
    output logic          busy_o,
    output logic          ready_o
);
    st_e           st;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start_i) begin
                        if (rom_i) begin
                            st <= ST_DONE;
                        end else begin
                            st  <= ST_WAIT;
                            cnt <= waits_i;
                        end
                    end
                end
                ST_WAIT: begin
                    if (cnt == '0) st <= ST_DONE;
                    else           cnt <= cnt - 1'b1;
                end
                ST_DONE: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy_o  = (st != ST_IDLE);
    assign ready_o = (st == ST_DONE);

    assert_ready_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        ready_o |=> !ready_o);

    assert_wait_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WAIT && cnt != '0) |=> (st == ST_WAIT && !ready_o));

    assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(4));
endmodule

// File: rtl/a0_bus_decoder.sv
module a0_bus_decoder
    import a0_pkg::*;
#(
    parameter int ADDR_W      = 28,
    parameter int ROM_BITS    = 16,
    parameter bit ROM_PRESENT = 1'b1,
    parameter bit FORCE_EXT   = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              strobe_i,
    input  logic [2:0]        mode_i,
    input  logic [1:0]        lw_i,
    output logic              rom_sel_o,
    output logic              cs_n_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [1:0]        width_o,
    output logic              ready_o
);
    target_t           tgt;
    logic              hit;
    logic [ADDR_W-1:0] rom_addr, ext_addr;
    logic              busy, start;
    logic              lat_rom;
    bw_e               lat_width;
    logic [ADDR_W-1:0] lat_addr;

    a0_mode_decode #(
        .ROM_PRESENT(ROM_PRESENT),
        .FORCE_EXT  (FORCE_EXT)
    ) mode_i0 (
        .mode_i(mode_i),
        .tgt_o (tgt)
    );

    a0_addr_fold #(
        .ADDR_W  (ADDR_W),
        .ROM_BITS(ROM_BITS)
    ) fold_i0 (
        .addr_i    (addr_i),
        .hit_o     (hit),
        .rom_addr_o(rom_addr),
        .ext_addr_o(ext_addr)
    );

    assign start = strobe_i && hit && !busy;

    a0_wait_seq #(.CW(CNT_W)) seq_i0 (
        .clk    (clk),
        .rst    (rst),
        .start_i(start),
        .rom_i  (tgt.is_rom),
        .waits_i(waits_of(lw_i)),
        .busy_o (busy),
        .ready_o(ready_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_rom   <= 1'b0;
            lat_width <= BW_8;
            lat_addr  <= '0;
        end else if (start) begin
            lat_rom   <= tgt.is_rom;
            lat_width <= tgt.width;
            lat_addr  <= tgt.is_rom ? rom_addr : ext_addr;
        end
    end

    assign rom_sel_o  = busy && lat_rom;
    assign cs_n_o     = !(busy && !lat_rom);
    assign bus_addr_o = lat_addr;
    assign width_o    = lat_width;

    assert_cs_rom_excl_R5: assert property (@(posedge clk) disable iff (rst)
        !(rom_sel_o && !cs_n_o));

    assert_release_R8: assert property (@(posedge clk) disable iff (rst)
        ready_o |=> (cs_n_o && !rom_sel_o));

    assert_miss_ignored_R1: assert property (@(posedge clk) disable iff (rst)
        (!busy && strobe_i && !hit) |=> (cs_n_o && !rom_sel_o));

    assert_rom_fold_R4: assert property (@(posedge clk) disable iff (rst)
        rom_sel_o |-> (bus_addr_o[ADDR_W-1:ROM_BITS] == '0));

    assert_ext_fold_R6: assert property (@(posedge clk) disable iff (rst)
        !cs_n_o |-> (bus_addr_o[23:22] == 2'b00));

    assert_addr_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (!cs_n_o && !ready_o) |=> $stable(bus_addr_o) && $stable(width_o));
endmodule

// File: tb/a0_bus_decoder_tb_top.sv
module a0_bus_decoder_tb_top;
    localparam int ADDR_W = 28;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [ADDR_W-1:0] addr   = '0;
    logic              strobe = 1'b0;
    logic [2:0]        mode   = 3'b000;
    logic [1:0]        lw     = 2'b00;

    logic              rom_sel, cs_n, ready;
    logic [ADDR_W-1:0] bus_addr;
    logic [1:0]        width;
    logic              fx_rom_sel, fx_cs_n, fx_ready;
    logic [ADDR_W-1:0] fx_bus_addr;
    logic [1:0]        fx_width;

    a0_bus_decoder dut_i (
        .clk(clk), .rst(rst), .addr_i(addr), .strobe_i(strobe), .mode_i(mode), .lw_i(lw),
        .rom_sel_o(rom_sel), .cs_n_o(cs_n), .bus_addr_o(bus_addr), .width_o(width), .ready_o(ready)
    );

    a0_bus_decoder #(.FORCE_EXT(1'b1)) dut_fx_i (
        .clk(clk), .rst(rst), .addr_i(addr), .strobe_i(strobe), .mode_i(mode), .lw_i(lw),
        .rom_sel_o(fx_rom_sel), .cs_n_o(fx_cs_n), .bus_addr_o(fx_bus_addr), .width_o(fx_width),
        .ready_o(fx_ready)
    );

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;

    typedef struct {
        logic              is_rom;
        logic [1:0]        width;
        logic [ADDR_W-1:0] baddr;
        int                lat;
        string             req;
    } exp_t;
    exp_t q[$];

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // monitor: measure latency, pop and compare at each completion
    int   lat        = 0;
    bit   prev_ready = 1'b0;
    exp_t e;
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_ready)
                check(cs_n && !rom_sel && !ready, "R8", "release after ready",
                      {cs_n, rom_sel, ready}, 3'b100);
            if (ready) begin
                if (q.size() == 0) begin
                    check(1'b0, "R9", "completion with nothing pending", 1, 0);
                end else begin
                    e = q.pop_front();
                    check(rom_sel == e.is_rom && cs_n == e.is_rom, e.req, "target sel/cs_n",
                          {rom_sel, cs_n}, {e.is_rom, e.is_rom});
                    check(width == e.width, e.req, "width", width, e.width);
                    check(bus_addr == e.baddr, e.req, "bus_addr", bus_addr, e.baddr);
                    check(lat == e.lat, e.req, "latency", lat, e.lat);
                end
                lat = 0;
            end else if (rom_sel || !cs_n) begin
                lat++;
            end
            prev_ready = ready;
        end
    end

    // watchdog
    always @(negedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            n_err++;
            n_chk++;
            $display("FAIL R7 watchdog expired actual=%0d expected=%0d", cyc, 50000);
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    // driver: push expectation, issue strobe, scramble inputs (R11), re-strobe mid-access (R9)
    task automatic access(input logic [ADDR_W-1:0] a, input logic [2:0] m,
                          input logic [1:0] l, input string req);
        exp_t x;
        bit   rom;
        rom      = (m == 3'b010);
        x.is_rom = rom;
        x.width  = rom ? 2'b10 : ((m == 3'b001) ? 2'b01 : 2'b00);
        x.baddr  = rom ? {12'h000, a[15:0]} : (a & ~28'h0C00000);
        x.lat    = rom ? 0 : int'(l) + 2;
        x.req    = req;
        q.push_back(x);
        @(negedge clk);
        addr = a; mode = m; lw = l; strobe = 1'b1;
        @(negedge clk);
        if (m == 3'b010)
            check(!fx_cs_n && !fx_rom_sel && fx_width == 2'b00, "R10", "forced external",
                  {fx_cs_n, fx_rom_sel, fx_width}, 4'b0000);
        strobe = 1'b0;
        addr   = ~a & 28'h8FFFFFF;
        mode   = m ^ 3'b011;
        lw     = ~l;
        if (!rom) begin
            @(negedge clk);
            strobe = 1'b1;
            @(negedge clk);
            strobe = 1'b0;
        end
        repeat (8) @(negedge clk);
    endtask

    task automatic miss(input logic [ADDR_W-1:0] a);
        @(negedge clk);
        addr = a; mode = 3'b000; lw = 2'b00; strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
        check(cs_n && !rom_sel && !ready, "R1", "miss ignored", {cs_n, rom_sel, ready}, 3'b100);
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(cs_n && !rom_sel && !ready && width == 2'b00 && bus_addr == '0, "R8",
              "reset state", {cs_n, rom_sel, ready}, 3'b100);

        access(28'h0ABCDEF, 3'b010, 2'b11, "R5");   // ROM, fold to 64 KB (R4, R2)
        access(28'h8F31234, 3'b010, 2'b00, "R1");   // ROM via bit-27 image
        access(28'h0FFFFFF, 3'b000, 2'b00, "R6");   // ext8, 1 wait, drop 23:22
        access(28'h8C12345, 3'b001, 2'b11, "R2");   // ext16, 4 waits, bit 27 kept
        access(28'h0512340, 3'b001, 2'b01, "R7");   // 2 waits
        access(28'h0812345, 3'b000, 2'b10, "R7");   // 3 waits
        access(28'h0400010, 3'b111, 2'b10, "R3");   // undefined mode -> 8-bit
        access(28'h8A00F00, 3'b011, 2'b01, "R3");
        access(28'h0001234, 3'b100, 2'b00, "R11");
        miss(28'h1000000);
        miss(28'h9000000);
        miss(28'h7FFFFFF);
        access(28'h00FFFFF, 3'b010, 2'b01, "R4");

        repeat (4) @(negedge clk);
        check(q.size() == 0, "R9", "pending expectations", q.size(), 0);
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule